// File: doc/BRIEF.md
# NAND Bus Cycle Engine

This block sits behind a small register-mapped slave port and turns processor register accesses into byte-wide cycles on a NAND flash bus. Writing the command register sends one command byte with the command latch line high. Writing the address register sends one address byte with the address latch line high. Each 32-bit access to the data register becomes four byte cycles on the flash bus: a write splits the word, a read gathers four bytes back into a word. The least significant byte always goes first.

Three programmable counts shape every byte cycle: how many clocks the latch lines lead the strobe, how long the strobe stays low, and how many clocks the latch lines are held after the strobe rises. Software selects the device with a chip-enable control bit. It tracks device completion by polling a synchronized copy of the ready/busy input, or by enabling a sticky interrupt that is set on the rising edge of ready. A register write that arrives while a byte cycle is running is stalled with a wait signal. A data-register read is held until all four bytes have been sampled.

Top module: `nand_cycle_engine`

## Requirements
- R1: A write to register index 2 produces exactly one byte cycle. During it, nand_cle is high, nand_ale is low, nand_we_n pulses low, and nand_io_out carries bus_wdata[7:0].
- R2: A write to register index 3 produces exactly one byte cycle. During it, nand_ale is high, nand_cle is low, nand_we_n pulses low, and nand_io_out carries bus_wdata[7:0].
- R3: A write to register index 4 produces four nand_we_n pulses with nand_cle and nand_ale low. The bytes are sent in the order bus_wdata[7:0], [15:8], [23:16], [31:24]. nand_io_out stays stable while the strobe is low.
- R4: A read of register index 4 holds bus_wait high while four nand_re_n pulses run. Each byte is sampled at the end of its low phase and placed as follows: first byte in bus_rdata[7:0], second in [15:8], third in [23:16], fourth in [31:24]. The assembled word is presented in the cycle in which bus_wait drops.
- R5: Register index 0 holds the timing. Bits [3:0] set the number of clocks nand_cle or nand_ale is high before the strobe falls. Bits [7:4] plus one set the number of clocks the strobe stays low. Bits [11:8] set the number of clocks nand_cle or nand_ale stays high after the strobe rises. The reset value is 0x777.
- R6: Any register write that arrives while a byte cycle is in progress sees bus_wait high until the engine is idle. Reads of registers other than index 4 never wait.
- R7: Bit 0 of register index 1 drives nand_ce_n low when it is 1. After reset, nand_ce_n is high.
- R8: Register index 5 behaves as follows.
  - Bit 0 reads nand_rdy after a two-flop synchronizer.
  - Bit 1 is a sticky flag, set on a rising edge of the synchronized ready. The irq output mirrors it.
  - Writing 1 to bit 1 clears the flag. Writing 0 has no effect.
  - A falling edge of ready does not set the flag.
- R9: nand_we_n and nand_re_n are never low together, and nand_cle and nand_ale are never high together. nand_io_oe is high only during write-type cycles, never while nand_re_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, held until accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_req is high and bus_wait is low |
| bus_wait | output | 1 | Stall: the access is not accepted this cycle |
| nand_ce_n | output | 1 | Active-low chip enable |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_out | output | 8 | Byte driven towards the device |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte returned from the device |
| nand_rdy | input | 1 | Asynchronous ready (1) / busy (0) from the device |
| irq | output | 1 | Sticky ready-rise interrupt |

## Verification
The bench measures the lead, low and hold lengths in clocks and checks them against the programmed fields, including all-zero fields. A design that counted one cycle too many or too few, or that dropped a latch line together with the strobe despite a non-zero hold, would show a wrong count. Data bytes are compared one by one in order, in both directions, so a big-endian split or a misplaced read byte fails at once. Back-to-back address writes, and a timing write issued during a running data write, must stall. A timing-register read at that moment must not stall, which catches both a missing stall and an overly broad stall. For the interrupt, a rising edge must set it, writing 0 must leave it set, writing 1 must clear it, and a falling edge must not set it again.

// File: rtl/nce_pkg.sv
package nce_pkg;
  localparam int unsigned NCE_TW = 4;
  localparam int unsigned NCE_AW = 3;

  localparam logic [NCE_AW-1:0] RA_TIMING = 3'd0;
  localparam logic [NCE_AW-1:0] RA_CTRL   = 3'd1;
  localparam logic [NCE_AW-1:0] RA_CMD    = 3'd2;
  localparam logic [NCE_AW-1:0] RA_ADDR   = 3'd3;
  localparam logic [NCE_AW-1:0] RA_DATA   = 3'd4;
  localparam logic [NCE_AW-1:0] RA_STAT   = 3'd5;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WR, OP_RD} nce_op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_LOW, PH_TAIL} nce_phase_e;

  typedef struct packed {
    logic [NCE_TW-1:0] tail;
    logic [NCE_TW-1:0] low;
    logic [NCE_TW-1:0] lead;
  } nce_timing_t;
endpackage

// File: rtl/nce_sync.sv
module nce_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= 1'b0;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= 1'b0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nce_seq.sv
module nce_seq import nce_pkg::*; #(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned IO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  nce_op_e           op_i,
  input  logic [BUS_W-1:0]  word_i,
  input  nce_timing_t       tim_i,
  input  logic [IO_W-1:0]   io_in_i,
  output logic              busy_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_n_o,
  output logic              re_n_o,
  output logic              io_oe_o,
  output logic [IO_W-1:0]   io_out_o,
  output logic [BUS_W-1:0]  rd_word_o,
  output logic              rd_done_o
);
  localparam int unsigned NB = BUS_W / IO_W;
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

  nce_phase_e        phase_q, phase_d;
  nce_op_e           op_q, op_d;
  logic [NCE_TW-1:0] cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [BUS_W-1:0]  word_q, word_d;
  logic [BUS_W-1:0]  rd_q, rd_d;
  logic              last_byte, step_end, begin_cyc, done;

  always_comb begin
    phase_d   = phase_q;
    op_d      = op_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    word_d    = word_q;
    rd_d      = rd_q;
    step_end  = 1'b0;
    begin_cyc = 1'b0;
    done      = 1'b0;
    last_byte = (op_q == OP_CMD || op_q == OP_ADDR) ? 1'b1 : (idx_q == LAST_IDX);

    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          op_d      = op_i;
          word_d    = word_i;
          idx_d     = '0;
          begin_cyc = 1'b1;
        end
      end
      PH_LEAD: begin
        if (cnt_q == '0) begin
          phase_d = PH_LOW;
          cnt_d   = tim_i.low;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_LOW: begin
        if (cnt_q == '0) begin
          if (op_q == OP_RD) rd_d[idx_q*IO_W +: IO_W] = io_in_i;
          if (tim_i.tail != '0) begin
            phase_d = PH_TAIL;
            cnt_d   = tim_i.tail - 1'b1;
          end else begin
            step_end = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_TAIL: begin
        if (cnt_q == '0) step_end = 1'b1;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase

    if (step_end) begin
      if (last_byte) begin
        phase_d = PH_IDLE;
        done    = 1'b1;
      end else begin
        idx_d     = idx_q + 1'b1;
        begin_cyc = 1'b1;
      end
    end

    if (begin_cyc) begin
      if (tim_i.lead != '0) begin
        phase_d = PH_LEAD;
        cnt_d   = tim_i.lead - 1'b1;
      end else begin
        phase_d = PH_LOW;
        cnt_d   = tim_i.low;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_CMD;
      cnt_q   <= '0;
      idx_q   <= '0;
      word_q  <= '0;
      rd_q    <= '0;
    end else begin
      phase_q <= phase_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      word_q  <= word_d;
      rd_q    <= rd_d;
    end
  end

  assign busy_o    = (phase_q != PH_IDLE);
  assign cle_o     = busy_o && (op_q == OP_CMD);
  assign ale_o     = busy_o && (op_q == OP_ADDR);
  assign we_n_o    = !((phase_q == PH_LOW) && (op_q != OP_RD));
  assign re_n_o    = !((phase_q == PH_LOW) && (op_q == OP_RD));
  assign io_oe_o   = busy_o && (op_q != OP_RD);
  assign io_out_o  = word_q[idx_q*IO_W +: IO_W];
  assign rd_word_o = rd_q;
  assign rd_done_o = done && (op_q == OP_RD);
endmodule

// File: rtl/nce_regs.sv
module nce_regs import nce_pkg::*; #(
  parameter int unsigned        BUS_W    = 32,
  parameter logic [3*NCE_TW-1:0] RST_TIME = 12'h777
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [NCE_AW-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              wait_o,
  input  logic              seq_busy_i,
  input  logic              seq_rd_done_i,
  input  logic [BUS_W-1:0]  seq_rd_word_i,
  output logic              start_o,
  output nce_op_e           op_o,
  output nce_timing_t       tim_o,
  output logic              ce_n_o,
  input  logic              rdy_sync_i,
  output logic              irq_o
);
  logic [3*NCE_TW-1:0] time_q, time_d;
  logic                ce_q, ce_d;
  logic                irq_q, irq_d;
  logic                rdv_q, rdv_d;
  logic                rdy_prev_q;
  logic                data_rd, seq_reg, accept, wr_acc;

  always_comb begin
    data_rd = req_i && !we_i && (addr_i == RA_DATA);
    seq_reg = (addr_i == RA_CMD) || (addr_i == RA_ADDR) || (addr_i == RA_DATA);
    wait_o  = req_i && ((we_i && seq_busy_i) || (data_rd && !rdv_q));
    accept  = req_i && !wait_o;
    wr_acc  = accept && we_i;
    start_o = (wr_acc && seq_reg) || (data_rd && !seq_busy_i && !rdv_q);

    unique case (addr_i)
      RA_CMD:  op_o = OP_CMD;
      RA_ADDR: op_o = OP_ADDR;
      default: op_o = we_i ? OP_WR : OP_RD;
    endcase

    time_d = time_q;
    ce_d   = ce_q;
    irq_d  = irq_q;
    rdv_d  = rdv_q;
    if (wr_acc && addr_i == RA_TIMING) time_d = wdata_i[3*NCE_TW-1:0];
    if (wr_acc && addr_i == RA_CTRL)   ce_d   = wdata_i[0];
    if (wr_acc && addr_i == RA_STAT && wdata_i[1]) irq_d = 1'b0;
    if (rdy_sync_i && !rdy_prev_q)                 irq_d = 1'b1;
    if (accept && data_rd) rdv_d = 1'b0;
    if (seq_rd_done_i)     rdv_d = 1'b1;

    unique case (addr_i)
      RA_TIMING: rdata_o = BUS_W'(time_q);
      RA_CTRL:   rdata_o = BUS_W'(ce_q);
      RA_DATA:   rdata_o = seq_rd_word_i;
      RA_STAT:   rdata_o = BUS_W'({irq_q, rdy_sync_i});
      default:   rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q     <= RST_TIME;
      ce_q       <= 1'b0;
      irq_q      <= 1'b0;
      rdv_q      <= 1'b0;
      rdy_prev_q <= 1'b0;
    end else begin
      time_q     <= time_d;
      ce_q       <= ce_d;
      irq_q      <= irq_d;
      rdv_q      <= rdv_d;
      rdy_prev_q <= rdy_sync_i;
    end
  end

  assign tim_o  = nce_timing_t'(time_q);
  assign ce_n_o = !ce_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine import nce_pkg::*; #(
  parameter int unsigned        BUS_W    = 32,
  parameter int unsigned        IO_W     = 8,
  parameter int unsigned        SYNC_N   = 2,
  parameter logic [3*NCE_TW-1:0] RST_TIME = 12'h777
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [NCE_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_wait,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [IO_W-1:0]   nand_io_out,
  output logic              nand_io_oe,
  input  logic [IO_W-1:0]   nand_io_in,
  input  logic              nand_rdy,
  output logic              irq
);
  logic             rst_n_int;
  logic             rdy_sync;
  logic             seq_busy, seq_rd_done, seq_start;
  logic [BUS_W-1:0] seq_rd_word;
  nce_op_e          seq_op;
  nce_timing_t      tim;

  nce_sync #(.STAGES(SYNC_N)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_int)
  );

  nce_sync #(.STAGES(SYNC_N)) i_rdy_sync (
    .clk(clk), .rst_n(rst_n_int), .d_i(nand_rdy), .q_o(rdy_sync)
  );

  nce_regs #(.BUS_W(BUS_W), .RST_TIME(RST_TIME)) i_regs (
    .clk(clk), .rst_n(rst_n_int),
    .req_i(bus_req), .we_i(bus_we), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .rdata_o(bus_rdata), .wait_o(bus_wait),
    .seq_busy_i(seq_busy), .seq_rd_done_i(seq_rd_done), .seq_rd_word_i(seq_rd_word),
    .start_o(seq_start), .op_o(seq_op), .tim_o(tim),
    .ce_n_o(nand_ce_n), .rdy_sync_i(rdy_sync), .irq_o(irq)
  );

  nce_seq #(.BUS_W(BUS_W), .IO_W(IO_W)) i_seq (
    .clk(clk), .rst_n(rst_n_int),
    .start_i(seq_start), .op_i(seq_op), .word_i(bus_wdata), .tim_i(tim),
    .io_in_i(nand_io_in),
    .busy_o(seq_busy), .cle_o(nand_cle), .ale_o(nand_ale),
    .we_n_o(nand_we_n), .re_n_o(nand_re_n), .io_oe_o(nand_io_oe),
    .io_out_o(nand_io_out), .rd_word_o(seq_rd_word), .rd_done_o(seq_rd_done)
  );
endmodule

// File: rtl/nce_checker.sv
module nce_checker #(
  parameter int unsigned IO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_req,
  input logic            bus_we,
  input logic            bus_wait,
  input logic            seq_busy,
  input logic            nand_cle,
  input logic            nand_ale,
  input logic            nand_we_n,
  input logic            nand_re_n,
  input logic            nand_io_oe,
  input logic [IO_W-1:0] nand_io_out,
  input logic            rdy_sync,
  input logic            irq
);
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  a_r9_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);

  a_r3_io_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |->
      ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale)));

  a_r6_stall_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && seq_busy) |-> bus_wait);

  a_r8_irq_after_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rdy_sync));
endmodule

bind nand_cycle_engine nce_checker #(.IO_W(IO_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_wait(bus_wait), .seq_busy(seq_busy), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_io_oe(nand_io_oe), .nand_io_out(nand_io_out),
  .rdy_sync(rdy_sync), .irq(irq)
);

// File: tb/test_nand_cycle_engine.sv
`timescale 1ns/1ps
module test_nand_cycle_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wait;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in = '0;
  logic        nand_rdy = 1'b0;
  logic        irq;

  always #4 clk = ~clk;

  nand_cycle_engine i_nand_cycle_engine (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wait(bus_wait), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rdy(nand_rdy), .irq(irq)
  );

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic       rd;
    logic       cle;
    logic       ale;
    logic [7:0] val;
    logic [7:0] lead;
    logic [7:0] low;
  } item_t;

  item_t      exp_q[$];
  string      exp_tag[$];
  logic [7:0] rd_src[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input string tag, input logic rd, input logic cle,
                             input logic ale, input logic [7:0] val,
                             input int lead, input int low);
    item_t it;
    it.rd = rd; it.cle = cle; it.ale = ale; it.val = val;
    it.lead = 8'(lead); it.low = 8'(low);
    exp_q.push_back(it);
    exp_tag.push_back(tag);
  endtask

  // Monitor: samples the flash side on falling clock edges.
  logic       in_low = 1'b0, post_on = 1'b0;
  int         low_cnt = 0, pre_cnt = 0, post_cnt = 0, last_hold = -1;
  item_t      cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n || !nand_re_n) begin
        if (!in_low) begin
          in_low  = 1'b1;
          low_cnt = 0;
          post_on = 1'b0;
          cur.rd  = !nand_re_n;
          cur.cle = nand_cle;
          cur.ale = nand_ale;
          cur.lead = 8'(pre_cnt);
          pre_cnt = 0;
          if (cur.rd) begin
            cur.val    = (rd_src.size() > 0) ? rd_src.pop_front() : 8'h00;
            nand_io_in = cur.val;
          end else begin
            cur.val = nand_io_out;
          end
        end
        low_cnt++;
      end else begin
        if (in_low) begin
          in_low   = 1'b0;
          cur.low  = 8'(low_cnt);
          post_on  = 1'b1;
          post_cnt = 0;
          if (exp_q.size() == 0) begin
            chk("R1 unexpected strobe", {8'd0, cur[23:0]}, 32'hFFFF_FFFF);
          end else begin
            item_t e;
            string t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            chk(t, {1'b0, cur[30:0]}, {1'b0, e[30:0]});
          end
        end
        if (nand_cle || nand_ale) begin
          pre_cnt++;
          if (post_on) post_cnt++;
        end else begin
          pre_cnt = 0;
          if (post_on) begin
            last_hold = post_cnt;
            post_on   = 1'b0;
          end
        end
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d, output int waits);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    waits = 0;
    #1;
    while (bus_wait) begin
      @(negedge clk); #1;
      waits++;
    end
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d, output int waits);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    waits = 0;
    #1;
    while (bus_wait) begin
      @(negedge clk); #1;
      waits++;
    end
    d = bus_rdata;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while ((exp_q.size() != 0 || !nand_we_n || !nand_re_n || nand_cle || nand_ale || post_on)
           && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R7 reset ce_n", {31'd0, nand_ce_n}, 32'd1);
    chk("R9 reset strobes", {30'd0, nand_we_n, nand_re_n}, 32'd3);
    chk("R9 reset latches", {30'd0, nand_cle, nand_ale}, 32'd0);
    chk("R8 reset irq", {31'd0, irq}, 32'd0);
    bus_read(3'd0, rd, w);
    chk("R5 reset timing", rd, 32'h777);

    // Timing: lead 2, low 3, hold 1
    bus_write(3'd0, 32'h122, w);
    bus_read(3'd0, rd, w);
    chk("R5 timing readback", rd, 32'h122);

    bus_write(3'd1, 32'h1, w);
    chk("R7 ce asserted", {31'd0, nand_ce_n}, 32'd0);

    // Command cycle
    expect_item("R1 command byte", 1'b0, 1'b1, 1'b0, 8'h80, 2, 3);
    bus_write(3'd2, 32'hFFFF_FF80, w);
    wait_idle();
    chk("R5 hold after command", 32'(last_hold), 32'd1);

    // Back-to-back address bytes
    expect_item("R2 address byte 0", 1'b0, 1'b0, 1'b1, 8'h12, 2, 3);
    expect_item("R2 address byte 1", 1'b0, 1'b0, 1'b1, 8'h34, 2, 3);
    bus_write(3'd3, 32'h12, w);
    bus_write(3'd3, 32'hAB34, w);
    chk("R6 second address write stalled", 32'(w > 0), 32'd1);
    wait_idle();

    // Data write, little-endian byte order
    expect_item("R3 data byte 0", 1'b0, 1'b0, 1'b0, 8'hD4, 0, 3);
    expect_item("R3 data byte 1", 1'b0, 1'b0, 1'b0, 8'hC3, 0, 3);
    expect_item("R3 data byte 2", 1'b0, 1'b0, 1'b0, 8'hB2, 0, 3);
    expect_item("R3 data byte 3", 1'b0, 1'b0, 1'b0, 8'hA1, 0, 3);
    bus_write(3'd4, 32'hA1B2_C3D4, w);
    bus_read(3'd0, rd, w);
    chk("R6 timing read while busy no wait", 32'(w), 32'd0);
    bus_write(3'd0, 32'h000, w);
    chk("R6 timing write while busy stalled", 32'(w > 0), 32'd1);
    wait_idle();

    // All-zero timing: no lead, one-clock strobe, no hold
    expect_item("R5 minimal command", 1'b0, 1'b1, 1'b0, 8'h70, 0, 1);
    bus_write(3'd2, 32'h70, w);
    wait_idle();
    chk("R5 zero hold", 32'(last_hold), 32'd0);

    // Data read
    bus_write(3'd0, 32'h321, w);
    rd_src = '{8'h11, 8'h22, 8'h33, 8'h44};
    expect_item("R4 read byte 0", 1'b1, 1'b0, 1'b0, 8'h11, 0, 3);
    expect_item("R4 read byte 1", 1'b1, 1'b0, 1'b0, 8'h22, 0, 3);
    expect_item("R4 read byte 2", 1'b1, 1'b0, 1'b0, 8'h33, 0, 3);
    expect_item("R4 read byte 3", 1'b1, 1'b0, 1'b0, 8'h44, 0, 3);
    bus_read(3'd4, rd, w);
    chk("R4 assembled word", rd, 32'h4433_2211);
    chk("R4 read waited", 32'(w > 0), 32'd1);
    wait_idle();

    rd_src = '{8'hEF, 8'hBE, 8'hAD, 8'hDE};
    for (int i = 0; i < 4; i++)
      expect_item("R4 second read byte", 1'b1, 1'b0, 1'b0, 8'(32'hDEAD_BEEF >> (8*i)), 0, 3);
    bus_read(3'd4, rd, w);
    chk("R4 second word", rd, 32'hDEAD_BEEF);
    wait_idle();

    // Ready/busy and interrupt
    bus_read(3'd5, rd, w);
    chk("R8 busy status", rd, 32'h0);
    nand_rdy = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(3'd5, rd, w);
    chk("R8 ready and sticky flag", rd, 32'h3);
    chk("R8 irq output", {31'd0, irq}, 32'd1);
    bus_write(3'd5, 32'h0, w);
    bus_read(3'd5, rd, w);
    chk("R8 write 0 keeps flag", rd, 32'h3);
    bus_write(3'd5, 32'h2, w);
    chk("R8 write 1 clears irq", {31'd0, irq}, 32'd0);
    nand_rdy = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(3'd5, rd, w);
    chk("R8 falling edge ignored", rd, 32'h0);

    bus_write(3'd1, 32'h0, w);
    chk("R7 ce released", {31'd0, nand_ce_n}, 32'd1);

    chk("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule